// File: doc/BRIEF.md
# Nibble-Register BCD Calendar Clock

This block keeps wall-clock time and date as a set of single BCD digits, one digit per 4-bit register: seconds, minutes, hours, day of month, month, two-digit year and day of week. A host reaches all sixteen registers through a 4-bit index on a simple synchronous port. Writes land on the clock edge and reads are combinational from the index. Three of the indices are control nibbles. They hold the snapshot handshake, the interrupt flag, the rounding request, the interrupt period and output style, and the run, stop and 12/24-hour settings.

Time advances on a one-cycle 1 Hz enable. A separate 64 Hz enable feeds only the periodic interrupt. Every accepted second tick spends one cycle in a "busy" stage and is applied to the digits at the end of that cycle. To take a consistent snapshot, a host sets HOLD and reads BUSY. If BUSY is clear, no update will land while HOLD stays set. Seconds that arrive during HOLD are not lost: one of them is remembered and applied when HOLD is released. The day/month logic uses a four-year leap rule.

Top module: `rtc_nibble_clock`

## Requirements
- R1: Register index map: 0/1 seconds units/tens, 2/3 minutes units/tens, 4/5 hours units/tens, 6/7 day units/tens, 8/9 month units/tens, 10/11 year units/tens, 12 weekday, 13 control-D, 14 control-E, 15 control-F. Reads return the nibble in rdata[3:0] and zero above it, and write bits above bit 3 are ignored. After reset the clock reads 00:00:00, day 01, month 01, year 00, weekday 0, control-D 0, control-E 0 and control-F 4'b0100. Control-F bit3 always reads 0, and control-D bit1 (BUSY) is read-only.
- R2: Each applied second increments the BCD seconds. 59 wraps to 00 and increments minutes, and minute 59 wraps to 00 and carries into hours.
- R3: With control-F bit2 = 1 (24-hour), hours count 00..23, and 23 wraps to 00 with a day carry. Tens-of-hours bits 1:0 hold the tens digit.
- R4: With control-F bit2 = 0 (12-hour), hours run 12,01,..,11. Tens-of-hours bit2 is PM and toggles on the 11→12 step, and the PM→AM toggle carries into the day.
- R5: The day wraps to 01 after the last day of its month (30 for months 4, 6, 9 and 11, 31 for the others, and February 29 when the year is a multiple of 4, else 28), then increments the month. Month 12 wraps to 01 and increments the year, and year 99 wraps to 00.
- R6: Each day carry increments the weekday, which wraps from 6 to 0.
- R7: While control-D bit0 (HOLD) is 1, accepted seconds are not applied. At most one is remembered and is applied two cycles after HOLD is cleared.
- R8: Control-D bit1 (BUSY) reads 1 during the one cycle between sampling a second tick and applying it. Setting HOLD in that cycle does not stop that update.
- R9: Writing 1 to control-D bit3 rounds the seconds on the next cycle. Seconds 30..59 clear to 00 and carry into minutes, seconds 00..29 clear to 00, and the bit then reads 0.
- R10: Control-E bits 3:2 select the interrupt event: 0 = each 64 Hz enable, 1 = each applied second, 2 = each minute wrap, 3 = each hour wrap. An event sets control-D bit2 (flag). Writing control-D with bit2 = 0 clears the flag, and writing it with bit2 = 1 leaves it unchanged.
- R11: irq_out is 0 while control-E bit0 is 1. Otherwise it follows the flag when control-E bit1 = 1, and is a one-cycle pulse per event when control-E bit1 = 0.
- R12: While control-F bit1 (stop) or bit0 (reset) is 1, second ticks and 64 Hz enables are ignored and nothing is left pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle 1 Hz advance enable |
| fast_tick | input | 1 | One-cycle 64 Hz enable for the interrupt |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register index |
| wdata | input | DATA_W | Write data, low nibble used |
| rdata | output | DATA_W | Read data for addr, upper bits zero |
| irq_out | output | 1 | Periodic interrupt / pulse output |

## Verification
The bench sweeps every hour in both hour modes across the minute-to-hour boundary. It also pushes every month to its last day over a full four-year leap cycle and the 99 year. An error in any of these shows as a wrong digit or a missed or extra carry, for example 12 PM read back as 00, or February rolling over a day early in a leap year. The snapshot handshake is checked for three faults: a second applied under HOLD, more than one second remembered, and an in-flight update blocked by a late HOLD. The rounding is probed on both sides of 30 seconds. The interrupt is checked by period, by output style and by whether the flag clears, and stop and reset are checked to leave no pending second.

// File: rtl/rtc_nib_pkg.sv
`timescale 1ns/1ps
package rtc_nib_pkg;

    typedef logic [3:0] nib_t;

    localparam int IDX_W = 4;

    // register indices whose position is visible to software
    localparam logic [IDX_W-1:0] IX_WDAY = 4'd12;
    localparam logic [IDX_W-1:0] IX_CTLD = 4'd13;
    localparam logic [IDX_W-1:0] IX_CTLE = 4'd14;
    localparam logic [IDX_W-1:0] IX_CTLF = 4'd15;

    // control-D bits
    localparam int D_HOLD = 0;
    localparam int D_BUSY = 1;
    localparam int D_FLAG = 2;
    localparam int D_ADJ  = 3;
    // control-E bits
    localparam int E_MASK = 0;
    localparam int E_LVL  = 1;
    // control-F bits
    localparam int F_RST  = 0;
    localparam int F_STOP = 1;
    localparam int F_H24  = 2;

    typedef enum logic [1:0] {
        PER_FAST = 2'd0,
        PER_SEC  = 2'd1,
        PER_MIN  = 2'd2,
        PER_HOUR = 2'd3
    } period_e;

    typedef struct packed {
        nib_t wd;
        nib_t y10, y1;
        nib_t mo10, mo1;
        nib_t d10, d1;
        nib_t h10, h1;
        nib_t m10, m1;
        nib_t s10, s1;
    } clock_t;

    localparam clock_t CLOCK_RESET = '{wd: 4'd0, y10: 4'd0, y1: 4'd0,
                                       mo10: 4'd0, mo1: 4'd1,
                                       d10: 4'd0, d1: 4'd1,
                                       h10: 4'd0, h1: 4'd0,
                                       m10: 4'd0, m1: 4'd0,
                                       s10: 4'd0, s1: 4'd0};

    function automatic nib_t get_digit(clock_t c, logic [IDX_W-1:0] ix);
        nib_t v;
        case (ix)
            4'd0:  v = c.s1;
            4'd1:  v = c.s10;
            4'd2:  v = c.m1;
            4'd3:  v = c.m10;
            4'd4:  v = c.h1;
            4'd5:  v = c.h10;
            4'd6:  v = c.d1;
            4'd7:  v = c.d10;
            4'd8:  v = c.mo1;
            4'd9:  v = c.mo10;
            4'd10: v = c.y1;
            4'd11: v = c.y10;
            4'd12: v = c.wd;
            default: v = 4'd0;
        endcase
        return v;
    endfunction

    function automatic clock_t put_digit(clock_t c, logic [IDX_W-1:0] ix, nib_t v);
        clock_t r;
        r = c;
        case (ix)
            4'd0:  r.s1   = v;
            4'd1:  r.s10  = v;
            4'd2:  r.m1   = v;
            4'd3:  r.m10  = v;
            4'd4:  r.h1   = v;
            4'd5:  r.h10  = v;
            4'd6:  r.d1   = v;
            4'd7:  r.d10  = v;
            4'd8:  r.mo1  = v;
            4'd9:  r.mo10 = v;
            4'd10: r.y1   = v;
            4'd11: r.y10  = v;
            4'd12: r.wd   = v;
            default: ;
        endcase
        return r;
    endfunction

    // leap test on a BCD year: multiple of 4
    function automatic logic is_leap(nib_t y10, nib_t y1);
        if (y10[0])
            return (y1 == 4'd2) || (y1 == 4'd6);
        return (y1 == 4'd0) || (y1 == 4'd4) || (y1 == 4'd8);
    endfunction

    // last day of the month as two BCD digits
    function automatic logic [7:0] last_day(nib_t mo10, nib_t mo1, nib_t y10, nib_t y1);
        logic [7:0] mo;
        mo = {mo10, mo1};
        if (mo == 8'h02)
            return is_leap(y10, y1) ? 8'h29 : 8'h28;
        if (mo == 8'h04 || mo == 8'h06 || mo == 8'h09 || mo == 8'h11)
            return 8'h30;
        return 8'h31;
    endfunction

    // two-digit BCD increment with wrap at wrap_at
    function automatic logic [7:0] bcd2_step(nib_t hi, nib_t lo, logic [7:0] wrap_at,
                                             logic [7:0] restart);
        if ({hi, lo} == wrap_at)
            return restart;
        if (lo == 4'd9)
            return {hi + 4'd1, 4'd0};
        return {hi, lo + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_step_ctrl.sv
`timescale 1ns/1ps
module rtc_step_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic run,
    input  logic hold,
    output logic step
);
    logic accept;
    logic pend_q;
    logic step_q;

    assign accept = tick & run;
    assign step   = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            step_q <= !hold && (accept || pend_q);
            if (hold)
                pend_q <= pend_q | accept;
            else
                pend_q <= pend_q & accept;
        end
    end

    // R7: a new update never starts while HOLD was set
    a_r7_step_needs_release: assert property (@(posedge clk) disable iff (rst)
        $rose(step_q) |-> !$past(hold));

    // R7: one remembered second stays until HOLD is released
    a_r7_pend_kept: assert property (@(posedge clk) disable iff (rst)
        (pend_q && hold) |=> pend_q);

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_nib_pkg::*;
(
    input  clock_t cur,
    input  logic   mode24,
    input  logic   do_step,
    input  logic   do_adj,
    output clock_t nxt,
    output logic   ev_min,
    output logic   ev_hour
);
    logic sec_full, min_full;
    logic min_inc, hour_inc, day_inc, mon_inc, year_inc;
    logic [7:0] pair;
    logic [1:0] htens;
    logic       pm;

    always_comb begin
        nxt      = cur;
        sec_full = ({cur.s10, cur.s1} == 8'h59);
        min_full = ({cur.m10, cur.m1} == 8'h59);
        min_inc  = (do_step && sec_full) || (do_adj && cur.s10 >= 4'd3);
        hour_inc = min_inc && min_full;
        day_inc  = 1'b0;
        mon_inc  = 1'b0;
        year_inc = 1'b0;
        ev_min   = do_step && sec_full;
        ev_hour  = do_step && sec_full && min_full;
        htens    = cur.h10[1:0];
        pm       = cur.h10[2];
        pair     = 8'h00;

        // seconds
        if (do_step) begin
            pair = bcd2_step(cur.s10, cur.s1, 8'h59, 8'h00);
            {nxt.s10, nxt.s1} = pair;
        end else if (do_adj) begin
            nxt.s10 = 4'd0;
            nxt.s1  = 4'd0;
        end

        // minutes
        if (min_inc) begin
            pair = bcd2_step(cur.m10, cur.m1, 8'h59, 8'h00);
            {nxt.m10, nxt.m1} = pair;
        end

        // hours
        if (hour_inc) begin
            if (mode24) begin
                if (htens == 2'd2 && cur.h1 == 4'd3) begin
                    nxt.h10 = {cur.h10[3:2], 2'd0};
                    nxt.h1  = 4'd0;
                    day_inc = 1'b1;
                end else if (cur.h1 == 4'd9) begin
                    nxt.h10 = {cur.h10[3:2], htens + 2'd1};
                    nxt.h1  = 4'd0;
                end else begin
                    nxt.h1  = cur.h1 + 4'd1;
                end
            end else begin
                if (htens == 2'd1 && cur.h1 == 4'd2) begin
                    nxt.h10 = {cur.h10[3], pm, 2'd0};
                    nxt.h1  = 4'd1;
                end else if (htens == 2'd1 && cur.h1 == 4'd1) begin
                    nxt.h10 = {cur.h10[3], !pm, 2'd1};
                    nxt.h1  = 4'd2;
                    day_inc = pm;
                end else if (cur.h1 == 4'd9) begin
                    nxt.h10 = {cur.h10[3], pm, 2'd1};
                    nxt.h1  = 4'd0;
                end else begin
                    nxt.h1  = cur.h1 + 4'd1;
                end
            end
        end

        // day and weekday
        if (day_inc) begin
            nxt.wd = (cur.wd >= 4'd6) ? 4'd0 : cur.wd + 4'd1;
            if ({cur.d10, cur.d1} == last_day(cur.mo10, cur.mo1, cur.y10, cur.y1)) begin
                nxt.d10 = 4'd0;
                nxt.d1  = 4'd1;
                mon_inc = 1'b1;
            end else begin
                pair = bcd2_step(cur.d10, cur.d1, 8'h99, 8'h01);
                {nxt.d10, nxt.d1} = pair;
            end
        end

        // month
        if (mon_inc) begin
            year_inc = ({cur.mo10, cur.mo1} == 8'h12);
            pair = bcd2_step(cur.mo10, cur.mo1, 8'h12, 8'h01);
            {nxt.mo10, nxt.mo1} = pair;
        end

        // year
        if (year_inc) begin
            pair = bcd2_step(cur.y10, cur.y1, 8'h99, 8'h00);
            {nxt.y10, nxt.y1} = pair;
        end
    end

endmodule

// File: rtl/rtc_irq_gen.sv
`timescale 1ns/1ps
module rtc_irq_gen
    import rtc_nib_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ev_fast,
    input  logic    ev_sec,
    input  logic    ev_min,
    input  logic    ev_hour,
    input  period_e period,
    input  logic    level_mode,
    input  logic    mask,
    input  logic    clr_flag,
    output logic    flag,
    output logic    irq_out
);
    logic ev;
    logic flag_q, pulse_q;

    always_comb begin
        unique case (period)
            PER_FAST: ev = ev_fast;
            PER_SEC:  ev = ev_sec;
            PER_MIN:  ev = ev_min;
            PER_HOUR: ev = ev_hour;
            default:  ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= ev;
            if (ev)
                flag_q <= 1'b1;
            else if (clr_flag)
                flag_q <= 1'b0;
        end
    end

    assign flag    = flag_q;
    assign irq_out = !mask && (level_mode ? flag_q : pulse_q);

    // R10: flag is sticky until the host clears it
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_flag) |=> flag_q);

    // R11: pulse output lasts one cycle unless a new event follows
    a_r11_pulse_single: assert property (@(posedge clk) disable iff (rst)
        (pulse_q && !ev) |=> !pulse_q);

endmodule

// File: rtl/rtc_nibble_clock.sv
`timescale 1ns/1ps
module rtc_nibble_clock
    import rtc_nib_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick,
    input  logic              fast_tick,
    input  logic              wr_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_out
);
    localparam int PAD_W = DATA_W - 4;

    clock_t time_q, cal_nxt, time_d;
    logic   hold_q, adj_q;
    nib_t   ctl_e_q;
    logic   f_rst_q, f_stop_q, f_h24_q;
    logic   run, step, do_adj;
    logic   ev_min, ev_hour, flag;
    logic   wr_d, wr_e, wr_f, wr_digit;
    nib_t   wnib, rnib;

    assign wnib     = wdata[3:0];
    assign wr_d     = wr_en && (addr == IX_CTLD);
    assign wr_e     = wr_en && (addr == IX_CTLE);
    assign wr_f     = wr_en && (addr == IX_CTLF);
    assign wr_digit = wr_en && (addr <= IX_WDAY);
    assign run      = !f_stop_q && !f_rst_q;
    assign do_adj   = adj_q && !step;

    rtc_step_ctrl u_step (
        .clk  (clk),
        .rst  (rst),
        .tick (sec_tick),
        .run  (run),
        .hold (hold_q),
        .step (step)
    );

    rtc_calendar u_cal (
        .cur     (time_q),
        .mode24  (f_h24_q),
        .do_step (step),
        .do_adj  (do_adj),
        .nxt     (cal_nxt),
        .ev_min  (ev_min),
        .ev_hour (ev_hour)
    );

    rtc_irq_gen u_irq (
        .clk        (clk),
        .rst        (rst),
        .ev_fast    (fast_tick && run),
        .ev_sec     (step),
        .ev_min     (ev_min),
        .ev_hour    (ev_hour),
        .period     (period_e'(ctl_e_q[3:2])),
        .level_mode (ctl_e_q[E_LVL]),
        .mask       (ctl_e_q[E_MASK]),
        .clr_flag   (wr_d && !wnib[D_FLAG]),
        .flag       (flag),
        .irq_out    (irq_out)
    );

    // a host write to a digit wins over the counted value of that digit
    always_comb begin
        time_d = cal_nxt;
        if (wr_digit)
            time_d = put_digit(cal_nxt, addr, wnib);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q   <= CLOCK_RESET;
            hold_q   <= 1'b0;
            adj_q    <= 1'b0;
            ctl_e_q  <= 4'd0;
            f_rst_q  <= 1'b0;
            f_stop_q <= 1'b0;
            f_h24_q  <= 1'b1;
        end else begin
            time_q <= time_d;
            if (do_adj)
                adj_q <= 1'b0;
            if (wr_d) begin
                hold_q <= wnib[D_HOLD];
                if (wnib[D_ADJ])
                    adj_q <= 1'b1;
            end
            if (wr_e)
                ctl_e_q <= wnib;
            if (wr_f) begin
                f_rst_q  <= wnib[F_RST];
                f_stop_q <= wnib[F_STOP];
                f_h24_q  <= wnib[F_H24];
            end
        end
    end

    always_comb begin
        case (addr)
            IX_CTLD: rnib = {adj_q, flag, step, hold_q};
            IX_CTLE: rnib = ctl_e_q;
            IX_CTLF: rnib = {1'b0, f_h24_q, f_stop_q, f_rst_q};
            default: rnib = get_digit(time_q, addr);
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign rdata = {{PAD_W{1'b0}}, rnib};
        end else begin : g_nopad
            assign rdata = rnib;
        end
    endgenerate

    // R6: counting keeps a legal weekday legal
    a_r6_wday_range: assert property (@(posedge clk) disable iff (rst)
        (step && time_q.wd <= 4'd6 && !wr_en) |=> time_q.wd <= 4'd6);

    // R4: 11:59:59 in 12-hour mode flips PM on the next applied second
    a_r4_pm_flip: assert property (@(posedge clk) disable iff (rst)
        (step && !f_h24_q && time_q.h10[1:0] == 2'd1 && time_q.h1 == 4'd1 &&
         {time_q.m10, time_q.m1} == 8'h59 && {time_q.s10, time_q.s1} == 8'h59 && !wr_en)
        |=> (time_q.h10[2] != $past(time_q.h10[2])));

    // R9: a rounding request is consumed one cycle after it can run
    a_r9_adj_done: assert property (@(posedge clk) disable iff (rst)
        (adj_q && !step && !(wr_d && wnib[D_ADJ])) |=> !adj_q);

    // R12: while stopped or in reset, no new update starts from a fresh tick
    a_r12_no_run_no_step: assert property (@(posedge clk) disable iff (rst)
        (!run && !step && !hold_q && !wr_f) |=> !step || $past(hold_q));

endmodule

// File: tb/rtc_nibble_clock_tb.sv
`timescale 1ns/1ps
module rtc_nibble_clock_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       fast_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq_out;

    int total = 0;
    int bad = 0;

    // reference model, hours kept 0..23
    int s, m, h, d, mo, y, wd;
    bit mode12 = 0;

    always #4 clk = ~clk;

    rtc_nibble_clock #(.DATA_W(8)) u_dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .fast_tick(fast_tick),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        addr  = 4'(a);
        wdata = {4'hF, 4'(v)};
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        addr = 4'(a);
        #1;
        v = rdata;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        @(negedge clk);
    endtask

    function automatic int dim(input int mm, input int yy);
        if (mm == 2) return (yy % 4 == 0) ? 29 : 28;
        if (mm == 4 || mm == 6 || mm == 9 || mm == 11) return 30;
        return 31;
    endfunction

    task automatic day_up();
        wd = (wd == 6) ? 0 : wd + 1;
        if (d == dim(mo, y)) begin
            d = 1;
            mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
        end else d++;
    endtask

    task automatic adv();
        s++;
        if (s == 60) begin
            s = 0; m++;
            if (m == 60) begin
                m = 0; h++;
                if (h == 24) begin h = 0; day_up(); end
            end
        end
    endtask

    function automatic logic [7:0] hour_pair();
        int hh;
        if (!mode12) return {4'(h / 10), 4'(h % 10)};
        hh = h % 12;
        if (hh == 0) hh = 12;
        return {(h >= 12) ? 2'b01 : 2'b00, 2'(hh / 10), 4'(hh % 10)};
    endfunction

    function automatic logic [63:0] exp_vec();
        logic [7:0] hp;
        hp = hour_pair();
        return {12'd0, 4'(wd), 4'(y / 10), 4'(y % 10), 4'(mo / 10), 4'(mo % 10),
                4'(d / 10), 4'(d % 10), hp, 4'(m / 10), 4'(m % 10),
                4'(s / 10), 4'(s % 10)};
    endfunction

    task automatic set_time(input int ns, input int nm, input int nh, input int nd,
                            input int nmo, input int ny, input int nwd);
        logic [7:0] hp;
        s = ns; m = nm; h = nh; d = nd; mo = nmo; y = ny; wd = nwd;
        hp = hour_pair();
        wr(0, s % 10); wr(1, s / 10); wr(2, m % 10); wr(3, m / 10);
        wr(4, int'(hp[3:0])); wr(5, int'(hp[7:4]));
        wr(6, d % 10); wr(7, d / 10); wr(8, mo % 10); wr(9, mo / 10);
        wr(10, y % 10); wr(11, y / 10); wr(12, wd);
    endtask

    task automatic check_time(input string req);
        logic [63:0] act;
        logic [7:0]  v;
        act = '0;
        for (int i = 0; i < 13; i++) begin
            rd(i, v);
            act[i*4 +: 4] = v[3:0];
            @(negedge clk);
        end
        chk(req, act, exp_vec());
    endtask

    task automatic check_reg(input string req, input int a, input int exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, {56'd0, v}, 64'(exp));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values, upper read bits zero, test and busy bits
        s = 0; m = 0; h = 0; d = 1; mo = 1; y = 0; wd = 0;
        check_time("R1 reset time");
        check_reg("R1 reset ctl-D", 13, 0);
        check_reg("R1 reset ctl-E", 14, 0);
        check_reg("R1 reset ctl-F", 15, 4);
        for (int i = 0; i < 16; i++) begin
            rd(i, v);
            chk("R1 upper bits zero", {56'd0, v[7:4]}, 64'd0);
        end
        wr(15, 4'hC);
        check_reg("R1 test bit reads 0", 15, 4);
        wr(15, 4);
        wr(13, 4'h2);
        check_reg("R1 busy read-only", 13, 0);
        wr(13, 4'h4);

        // R2: seconds run through minute carries
        set_time(0, 58, 3, 5, 6, 7, 1);
        for (int i = 0; i < 130; i++) begin
            tick(); adv();
            check_time("R2 second count");
        end

        // R3: every hour, 24-hour mode
        for (int hh = 0; hh < 24; hh++) begin
            set_time(59, 59, hh, 10, 3, 5, 2);
            tick(); adv();
            check_time("R3 hour step 24h");
        end

        // R4: every hour, 12-hour mode
        mode12 = 1;
        wr(15, 0);
        for (int hh = 0; hh < 24; hh++) begin
            set_time(59, 59, hh, 10, 3, 5, 2);
            tick(); adv();
            check_time("R4 hour step 12h");
        end
        mode12 = 0;
        wr(15, 4);

        // R5: month ends over a leap cycle, plus year wrap
        for (int yy = 0; yy < 4; yy++) begin
            for (int mm = 1; mm <= 12; mm++) begin
                set_time(59, 59, 23, dim(mm, yy), mm, yy + 20, 3);
                tick(); adv();
                check_time("R5 month end");
            end
            set_time(59, 59, 23, 28, 2, yy + 20, 4);
            tick(); adv();
            check_time("R5 february 28");
        end
        set_time(59, 59, 23, 31, 12, 99, 5);
        tick(); adv();
        check_time("R5 year 99 wrap");

        // R6: weekday wrap
        set_time(59, 59, 23, 14, 7, 30, 6);
        tick(); adv();
        check_time("R6 weekday 6 to 0");

        // R7: hold keeps one pending second
        set_time(10, 20, 8, 9, 9, 9, 1);
        wr(13, 4'h5);
        tick(); tick();
        check_time("R7 no update under hold");
        wr(13, 4'h4);
        @(negedge clk); @(negedge clk);
        adv();
        check_time("R7 one pending applied");
        repeat (3) @(negedge clk);
        check_time("R7 only one remembered");

        // R8: busy cycle, late hold does not block the update
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        check_reg("R8 busy visible", 13, 4'h2);
        wr(13, 4'h5);
        adv();
        check_reg("R8 busy gone, hold set", 13, 4'h1);
        check_time("R8 update not frozen");
        wr(13, 4'h4);
        repeat (3) @(negedge clk);
        check_time("R8 nothing left pending");

        // R9: rounding on both sides of 30 s
        set_time(45, 20, 10, 2, 2, 2, 2);
        wr(13, 4'h8);
        @(negedge clk);
        s = 0; m = 21;
        check_time("R9 round up");
        check_reg("R9 adjust bit self-clears", 13, 0);
        set_time(12, 20, 10, 2, 2, 2, 2);
        wr(13, 4'h8);
        @(negedge clk);
        s = 0;
        check_time("R9 round down");
        set_time(40, 59, 23, 28, 2, 1, 6);
        wr(13, 4'h8);
        @(negedge clk);
        s = 0; m = 0; h = 0; d = 1; mo = 3; wd = 0;
        check_time("R9 round carries to day");

        // R10/R11: periodic interrupt
        wr(13, 4'h0);
        wr(14, 4'b0110);
        tick(); adv();
        check_reg("R10 second flag set", 13, 4'h4);
        chk("R11 level output", {63'd0, irq_out}, 64'd1);
        wr(13, 4'h4);
        check_reg("R10 write 1 keeps flag", 13, 4'h4);
        wr(13, 4'h0);
        check_reg("R10 write 0 clears flag", 13, 0);
        chk("R11 level follows flag", {63'd0, irq_out}, 64'd0);

        wr(14, 4'b1010);
        set_time(58, 3, 4, 5, 6, 7, 1);
        wr(13, 4'h0);
        tick(); adv();
        check_reg("R10 no minute event at 59", 13, 0);
        tick(); adv();
        check_reg("R10 minute event at wrap", 13, 4'h4);

        wr(14, 4'b1110);
        set_time(59, 58, 0, 5, 6, 7, 1);
        wr(13, 4'h0);
        tick(); adv();
        check_reg("R10 no hour event at :59:00", 13, 0);
        set_time(59, 59, 0, 5, 6, 7, 1);
        tick(); adv();
        check_reg("R10 hour event", 13, 4'h4);

        wr(14, 4'b0111);
        chk("R11 mask forces low", {63'd0, irq_out}, 64'd0);

        wr(14, 4'b0010);
        wr(13, 4'h0);
        fast_tick = 1'b1;
        @(negedge clk);
        fast_tick = 1'b0;
        check_reg("R10 fast event", 13, 4'h4);
        chk("R11 fast level out", {63'd0, irq_out}, 64'd1);

        wr(14, 4'b0100);
        wr(13, 4'h0);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        chk("R11 no pulse before update", {63'd0, irq_out}, 64'd0);
        @(negedge clk);
        adv();
        chk("R11 pulse high", {63'd0, irq_out}, 64'd1);
        @(negedge clk);
        chk("R11 pulse one cycle", {63'd0, irq_out}, 64'd0);

        // R12: stop and reset bits
        wr(14, 4'b0010);
        wr(13, 4'h0);
        wr(15, 4'b0110);
        tick(); tick();
        fast_tick = 1'b1;
        @(negedge clk);
        fast_tick = 1'b0;
        check_reg("R12 stop ignores fast tick", 13, 0);
        check_time("R12 stop ignores ticks");
        wr(15, 4'b0100);
        repeat (3) @(negedge clk);
        check_time("R12 stop leaves nothing pending");
        wr(15, 4'b0101);
        tick();
        check_time("R12 reset bit ignores ticks");
        wr(15, 4'b0100);
        tick(); adv();
        check_time("R12 runs again after release");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule